// File: doc/BRIEF.md
# Eight-Channel Serial Audio Output Formatter

This block takes frames of eight decoded 24-bit audio samples and four user bits from an upstream decoder. It shifts them out on four stereo serial data lanes, together with a word clock and a bit clock. The system clock serves as the master clock and runs at 256 times the sample rate. One frame lasts 256 system clocks. The bit clock period is four system clocks, so each channel half-frame holds 32 bit slots.

A two-bit format code selects the framing. The choices are right-justified data with the bit clock falling at word-clock edges, left-justified data with the bit clock rising at word-clock edges, or left-justified data with a gated bit clock. The fourth code holds the block in reset. In master mode the block runs its own frame counter and drives the word clock. In slave mode it resynchronises the frame counter to the rising edge of an external word clock.

Samples may come from 24-bit, 20-bit or 16-bit sources. A short source word is packed into the frame in one of two ways, depending on the justification:
- Right-justified framing sign-extends it to the left.
- Left-justified framing shifts it so that its MSB is sent first.

Top module: `audio_ser_fmt`

## Requirements
- R1: Lane k of `sdata_o` carries channel 2k while `wclk_o` is high and channel 2k+1 while it is low. Channel c is taken from `smp_data_i[c*24 +: 24]`.
- R2: One frame is 256 clocks long. `wclk_o` is high for the first 128 clocks of the frame. The bit clock has a period of 4 clocks, so each half-frame holds 32 bit slots, and every slot is sent MSB first.
- R3: With `fmt_i`=00, `bclk_o` is low for the first two clocks of each slot and high for the last two, so it falls at each word-clock transition. In each half-frame, slots 0..7 repeat the word MSB and slots 8..31 carry word bits 23..0. Data changes with the falling bit clock.
- R4: With `fmt_i`=01, `bclk_o` is high for the first two clocks of each slot and low for the last two. Slots 0..23 carry word bits 23..0 and slots 24..31 are zero. Each bit appears two clocks before its slot starts, on the preceding falling bit-clock edge.
- R5: With `fmt_i`=11, data is as in R4. `bclk_o` follows R4 in slots 0..23 and stays low in slots 24..31.
- R6: With `fmt_i`=10, all outputs are zero and stored samples are discarded. One clock after leaving this code a new frame starts, with `wclk_o` high.
- R7: `src_len_i` 00 (or 11) means a 24-bit source, 01 means a 20-bit source and 10 means a 16-bit source. A short sample sits in the low bits of its field. In right-justified framing it is sign-extended from its top bit. In left-justified framing it is shifted up so that its top bit is sent first and the trailing bits are zero.
- R8: With `mode_i`=01 (slave), the first clock edge that samples `wclk_i` high is followed by `wclk_o` rising on the third edge after it. With any other `mode_i`, `wclk_o` has a fixed 256-clock period and `wclk_i` has no effect.
- R9: A sample set offered with `smp_valid_i` is held pending and takes effect at the next frame boundary, not mid-frame. With no new set, the previous set is sent again.
- R10: `user_o` changes only on the clock edge at which `wclk_o` rises. It presents the user bits captured together with that frame's samples.
- R11: `mute_i` forces `sdata_o` to zero from the next clock and leaves the word and bit clocks running.
- R12: While `rst_ni` is low, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock, 256 x sample rate |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fmt_i | input | 2 | Framing code: 00 right-justified, 01 left-justified, 10 reset, 11 gated bit clock |
| mode_i | input | 2 | 01 slave, other codes master |
| src_len_i | input | 2 | Source word length code |
| mute_i | input | 1 | Forces the data lanes to zero |
| smp_valid_i | input | 1 | Offers a new sample set |
| smp_data_i | input | 192 | Eight 24-bit samples, channel 0 in the low bits |
| user_i | input | 4 | User bits accompanying the sample set |
| wclk_i | input | 1 | External word clock, used in slave mode |
| wclk_o | output | 1 | Word clock, high during the left half |
| bclk_o | output | 1 | Bit clock |
| sdata_o | output | 4 | Serial data lanes, one per channel pair |
| user_o | output | 4 | User bits for the current frame |

## Verification
Every output is registered once after the frame counter, so each result is due one clock after the counter state that produces it.

The bench locks onto the first sampled clock on which `wclk_o` is high and calls that frame position 0. From there it computes the expected `wclk_o`, `bclk_o` and lane values at each following falling edge. For left-justified codes it uses the frame position plus two, to model the early data launch.

Other results have fixed latencies, and the bench samples them exactly there:
- Slave alignment is due three edges after `wclk_i` is first sampled high.
- Mute and leaving the reset code act one clock later.
- A sample set offered mid-frame is expected only in the following frame.

// File: rtl/saf_pkg.sv
package saf_pkg;
  typedef enum logic [1:0] {
    FMT_RJ   = 2'b00,
    FMT_LJ   = 2'b01,
    FMT_RST  = 2'b10,
    FMT_GATE = 2'b11
  } fmt_e;

  typedef enum logic [1:0] {
    LEN_FULL  = 2'b00,
    LEN_MID   = 2'b01,
    LEN_SHORT = 2'b10,
    LEN_RSVD  = 2'b11
  } len_e;

  localparam logic [1:0] MODE_SLAVE = 2'b01;
endpackage

// File: rtl/saf_frame_timer.sv
module saf_frame_timer #(
  parameter int FRAME_CYC = 256,
  localparam int PH_W = $clog2(FRAME_CYC)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            run_i,
  input  logic            slave_i,
  input  logic            wclk_i,
  output logic [PH_W-1:0] ph_o
);
  logic [2:0]      sync_q;
  logic [PH_W-1:0] ph_q;
  logic            ext_rise;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[1:0], wclk_i};
  end

  assign ext_rise = sync_q[1] & ~sync_q[2];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          ph_q <= '0;
    else if (!run_i)                      ph_q <= '0;
    else if (slave_i && ext_rise)         ph_q <= '0;
    else if (ph_q == PH_W'(FRAME_CYC-1))  ph_q <= '0;
    else                                  ph_q <= ph_q + 1'b1;
  end

  assign ph_o = ph_q;
endmodule

// File: rtl/saf_sample_store.sv
module saf_sample_store #(
  parameter int N_CH  = 8,
  parameter int SMP_W = 24,
  parameter int USR_W = 4,
  localparam int DW = N_CH * SMP_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             vld_i,
  input  logic [DW-1:0]    data_i,
  input  logic [USR_W-1:0] user_i,
  input  logic             load_i,
  output logic [DW-1:0]    hold_o,
  output logic [USR_W-1:0] hold_user_o
);
  logic [DW-1:0]    pend_q, hold_q;
  logic [USR_W-1:0] pend_user_q, hold_user_q;
  logic             pend_vld_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q      <= '0;
      pend_user_q <= '0;
      pend_vld_q  <= 1'b0;
      hold_q      <= '0;
      hold_user_q <= '0;
    end else if (!run_i) begin
      pend_q      <= '0;
      pend_user_q <= '0;
      pend_vld_q  <= 1'b0;
      hold_q      <= '0;
      hold_user_q <= '0;
    end else if (load_i) begin
      // newest set wins at the boundary; otherwise repeat the held one
      if (vld_i) begin
        hold_q      <= data_i;
        hold_user_q <= user_i;
      end else if (pend_vld_q) begin
        hold_q      <= pend_q;
        hold_user_q <= pend_user_q;
      end
      pend_vld_q <= 1'b0;
    end else if (vld_i) begin
      pend_q      <= data_i;
      pend_user_q <= user_i;
      pend_vld_q  <= 1'b1;
    end
  end

  assign hold_o      = hold_q;
  assign hold_user_o = hold_user_q;
endmodule

// File: rtl/saf_lane_bit.sv
module saf_lane_bit import saf_pkg::*; #(
  parameter int SMP_W  = 24,
  parameter int SLOT_W = 32,
  localparam int SLOT_IW = $clog2(SLOT_W),
  localparam int IDX_W   = $clog2(SMP_W)
) (
  input  logic [SMP_W-1:0]   left_i,
  input  logic [SMP_W-1:0]   right_i,
  input  logic               right_sel_i,
  input  logic [SLOT_IW-1:0] slot_i,
  input  logic               rj_i,
  input  logic [1:0]         len_i,
  output logic               bit_o
);
  localparam int MID_W   = SMP_W - 4;
  localparam int SHORT_W = SMP_W - 8;
  localparam int PAD     = SLOT_W - SMP_W;

  logic [SMP_W-1:0] raw, word;
  logic [IDX_W-1:0] idx;
  int               s;

  always_comb begin
    raw = right_sel_i ? right_i : left_i;
    if (rj_i) begin
      unique case (len_i)
        LEN_MID:   word = {{(SMP_W-MID_W){raw[MID_W-1]}}, raw[MID_W-1:0]};
        LEN_SHORT: word = {{(SMP_W-SHORT_W){raw[SHORT_W-1]}}, raw[SHORT_W-1:0]};
        default:   word = raw;
      endcase
    end else begin
      unique case (len_i)
        LEN_MID:   word = {raw[MID_W-1:0], {(SMP_W-MID_W){1'b0}}};
        LEN_SHORT: word = {raw[SHORT_W-1:0], {(SMP_W-SHORT_W){1'b0}}};
        default:   word = raw;
      endcase
    end

    s     = int'(slot_i);
    idx   = '0;
    bit_o = 1'b0;
    if (rj_i) begin
      // leading pad slots repeat the MSB
      if (s < PAD) begin
        bit_o = word[SMP_W-1];
      end else begin
        idx   = IDX_W'(SLOT_W - 1 - s);
        bit_o = word[idx];
      end
    end else if (s < SMP_W) begin
      idx   = IDX_W'(SMP_W - 1 - s);
      bit_o = word[idx];
    end
  end
endmodule

// File: rtl/audio_ser_fmt.sv
module audio_ser_fmt import saf_pkg::*; #(
  parameter int SMP_W    = 24,
  parameter int N_LANE   = 4,
  parameter int SLOT_W   = 32,
  parameter int MCLK_DIV = 4,
  parameter int USR_W    = 4
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [1:0]                fmt_i,
  input  logic [1:0]                mode_i,
  input  logic [1:0]                src_len_i,
  input  logic                      mute_i,
  input  logic                      smp_valid_i,
  input  logic [2*N_LANE*SMP_W-1:0] smp_data_i,
  input  logic [USR_W-1:0]          user_i,
  input  logic                      wclk_i,
  output logic                      wclk_o,
  output logic                      bclk_o,
  output logic [N_LANE-1:0]         sdata_o,
  output logic [USR_W-1:0]          user_o
);
  localparam int N_CH      = 2 * N_LANE;
  localparam int HALF_CYC  = SLOT_W * MCLK_DIV;
  localparam int FRAME_CYC = 2 * HALF_CYC;
  localparam int PH_W      = $clog2(FRAME_CYC);
  localparam int SUB_W     = $clog2(MCLK_DIV);
  localparam int SLOT_IW   = $clog2(SLOT_W);
  localparam int LEAD      = MCLK_DIV / 2;
  localparam int DW        = N_CH * SMP_W;

  logic              run, slave, rj;
  logic [PH_W-1:0]   ph, ph_d;
  logic [SUB_W-1:0]  sub;
  logic [SLOT_IW-1:0] slot_now, slot_d;
  logic              half_d, bclk_n, load;
  logic [DW-1:0]     hold;
  logic [USR_W-1:0]  hold_user;
  logic [N_LANE-1:0] lane_bit;

  logic              wclk_q, bclk_q;
  logic [N_LANE-1:0] sdata_q;
  logic [USR_W-1:0]  user_q;

  assign run   = (fmt_i != FMT_RST);
  assign slave = (mode_i == MODE_SLAVE);
  assign rj    = (fmt_i == FMT_RJ);

  saf_frame_timer #(.FRAME_CYC(FRAME_CYC)) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .run_i   (run),
    .slave_i (slave),
    .wclk_i  (wclk_i),
    .ph_o    (ph)
  );

  // left-justified codes launch each bit half a slot early
  assign ph_d     = rj ? ph : ph + PH_W'(LEAD);
  assign sub      = ph[SUB_W-1:0];
  assign slot_now = ph[PH_W-2 -: SLOT_IW];
  assign slot_d   = ph_d[PH_W-2 -: SLOT_IW];
  assign half_d   = ph_d[PH_W-1];
  assign load     = run && (ph_d == PH_W'(FRAME_CYC-1));

  always_comb begin
    unique case (fmt_i)
      FMT_RJ:   bclk_n = (int'(sub) >= LEAD);
      FMT_LJ:   bclk_n = (int'(sub) < LEAD);
      FMT_GATE: bclk_n = (int'(sub) < LEAD) && (int'(slot_now) < SMP_W);
      default:  bclk_n = 1'b0;
    endcase
  end

  saf_sample_store #(.N_CH(N_CH), .SMP_W(SMP_W), .USR_W(USR_W)) u_store (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .run_i       (run),
    .vld_i       (smp_valid_i),
    .data_i      (smp_data_i),
    .user_i      (user_i),
    .load_i      (load),
    .hold_o      (hold),
    .hold_user_o (hold_user)
  );

  for (genvar l = 0; l < N_LANE; l++) begin : g_lane
    saf_lane_bit #(.SMP_W(SMP_W), .SLOT_W(SLOT_W)) u_lane (
      .left_i      (hold[(2*l)*SMP_W +: SMP_W]),
      .right_i     (hold[(2*l+1)*SMP_W +: SMP_W]),
      .right_sel_i (half_d),
      .slot_i      (slot_d),
      .rj_i        (rj),
      .len_i       (src_len_i),
      .bit_o       (lane_bit[l])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wclk_q  <= 1'b0;
      bclk_q  <= 1'b0;
      sdata_q <= '0;
      user_q  <= '0;
    end else if (!run) begin
      wclk_q  <= 1'b0;
      bclk_q  <= 1'b0;
      sdata_q <= '0;
      user_q  <= '0;
    end else begin
      wclk_q  <= ~ph[PH_W-1];
      bclk_q  <= bclk_n;
      sdata_q <= mute_i ? '0 : lane_bit;
      if (ph == '0) user_q <= hold_user;
    end
  end

  assign wclk_o  = wclk_q;
  assign bclk_o  = bclk_q;
  assign sdata_o = sdata_q;
  assign user_o  = user_q;
endmodule

// File: rtl/saf_checker.sv
module saf_checker #(
  parameter int N_LANE = 4,
  parameter int USR_W  = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [1:0]        fmt_i,
  input logic [1:0]        mode_i,
  input logic              mute_i,
  input logic              wclk_o,
  input logic              bclk_o,
  input logic [N_LANE-1:0] sdata_o,
  input logic [USR_W-1:0]  user_o
);
  logic       armed;
  logic [1:0] fmt_q, mode_q, age;
  logic       settled;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed  <= 1'b0;
      fmt_q  <= 2'b00;
      mode_q <= 2'b00;
      age    <= 2'd0;
    end else begin
      armed  <= 1'b1;
      fmt_q  <= fmt_i;
      mode_q <= mode_i;
      if (fmt_i != fmt_q || mode_i != mode_q) age <= 2'd0;
      else if (age != 2'd3)                   age <= age + 2'd1;
    end
  end

  assign settled = armed && (age == 2'd3) && (mode_i != 2'b01);

  // R6
  fmt_rst_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed && $past(fmt_i) == 2'b10 |-> !wclk_o && !bclk_o && sdata_o == '0 && user_o == '0);

  // R11
  mute_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed && $past(mute_i) |-> sdata_o == '0);

  // R10
  user_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    settled && !$rose(wclk_o) && $past(fmt_i) != 2'b10 |-> $stable(user_o));

  // R3
  rj_bclk_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    settled && fmt_i == 2'b00 && !$stable(wclk_o) |-> $fell(bclk_o));

  // R4
  lj_bclk_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    settled && fmt_i[0] && !$stable(wclk_o) |-> $rose(bclk_o));
endmodule

bind audio_ser_fmt saf_checker #(.N_LANE(N_LANE), .USR_W(USR_W)) u_saf_checker (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .fmt_i   (fmt_i),
  .mode_i  (mode_i),
  .mute_i  (mute_i),
  .wclk_o  (wclk_o),
  .bclk_o  (bclk_o),
  .sdata_o (sdata_o),
  .user_o  (user_o)
);

// File: tb/audio_ser_fmt_bench.sv
module audio_ser_fmt_bench;
  logic         clk, rst_ni;
  logic [1:0]   fmt_i, mode_i, src_len_i;
  logic         mute_i, smp_valid_i, wclk_i;
  logic [191:0] smp_data_i;
  logic [3:0]   user_i;
  logic         wclk_o, bclk_o;
  logic [3:0]   sdata_o, user_o;

  audio_ser_fmt u_audio_ser_fmt (
    .clk_i(clk), .rst_ni(rst_ni), .fmt_i(fmt_i), .mode_i(mode_i),
    .src_len_i(src_len_i), .mute_i(mute_i), .smp_valid_i(smp_valid_i),
    .smp_data_i(smp_data_i), .user_i(user_i), .wclk_i(wclk_i),
    .wclk_o(wclk_o), .bclk_o(bclk_o), .sdata_o(sdata_o), .user_o(user_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  logic [23:0] smp [8];
  logic [23:0] nxt [8];
  logic [3:0]  usr, nusr;

  // external word clock driver and wclk_o observer
  int  wper = 256, wcnt = 0, rise_at = -1, cyc = 0, last_rise = 0, per_meas = 0;
  bit  drv_run = 1'b0;
  logic prev_w = 1'b0;

  initial begin
    wclk_i = 1'b0;
    forever begin
      @(negedge clk);
      cyc++;
      if (wclk_o && !prev_w) begin
        rise_at   = wcnt;
        per_meas  = cyc - last_rise;
        last_rise = cyc;
      end
      prev_w = wclk_o;
      wcnt   = (wcnt + 1 >= wper) ? 0 : wcnt + 1;
      wclk_i = drv_run && (wcnt < wper / 2);
    end
  end

  task automatic chk(input bit ok, input string msg);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s", msg);
    end
  endtask

  function automatic int len_bits(input int code);
    return (code == 1) ? 20 : (code == 2) ? 16 : 24;
  endfunction

  function automatic logic exp_bit(input int fmt, input int len, input logic [23:0] raw, input int p);
    int sv;
    logic [23:0] lv;
    if (fmt == 0) begin
      sv = int'(raw);
      if (raw[len-1]) sv = sv - (1 << len);
      return 1'((sv >>> (31 - p)) & 1);
    end
    lv = raw << (24 - len);
    return (p < 24) ? lv[23 - p] : 1'b0;
  endfunction

  function automatic logic exp_bclk(input int fmt, input int t);
    int sub = t % 4;
    if (fmt == 0) return sub >= 2;
    if (fmt == 1) return sub < 2;
    return (sub < 2) && ((t % 128) / 4 < 24);
  endfunction

  task automatic gen_nxt(input int seed, input int len);
    for (int c = 0; c < 8; c++) begin
      logic [23:0] v;
      v = 24'((seed * 7919 + c * 40503 + 12345) & ((1 << len) - 1));
      v[len-1] = (c % 2 == 0);
      nxt[c] = v;
    end
    nusr = 4'(seed * 5 + 3);
  endtask

  task automatic drive_nxt();
    for (int c = 0; c < 8; c++) smp_data_i[c*24 +: 24] = nxt[c];
    user_i      = nusr;
    smp_valid_i = 1'b1;
  endtask

  task automatic push_set(input int seed, input int len);
    gen_nxt(seed, len);
    @(negedge clk);
    drive_nxt();
    @(negedge clk);
    smp_valid_i = 1'b0;
    for (int c = 0; c < 8; c++) smp[c] = nxt[c];
    usr = nusr;
  endtask

  // one frame, position 0 = first sample with wclk_o high
  task automatic check_frame(input int fmt, input int lcode, input bit muted,
                             input bit push_mid, input int seed, input string tag);
    logic pw;
    int guard = 0;
    int len = len_bits(lcode);
    @(negedge clk);
    pw = wclk_o;
    while (guard < 600) begin
      @(negedge clk);
      if (wclk_o && !pw) break;
      pw = wclk_o;
      guard++;
    end
    if (push_mid) gen_nxt(seed, len);
    for (int t = 0; t < 256; t++) begin
      logic [5:0] got, exp;
      int td, half, p;
      if (t > 0) @(negedge clk);
      td   = (fmt == 0) ? t : (t + 2) % 256;
      half = td / 128;
      p    = (td % 128) / 4;
      exp[5] = (t < 128);
      exp[4] = exp_bclk(fmt, t);
      for (int l = 0; l < 4; l++)
        exp[l] = muted ? 1'b0 : exp_bit(fmt, len, smp[2*l + half], p);
      got = {wclk_o, bclk_o, sdata_o};
      if (t == 0 || got != exp)
        chk(got == exp, $sformatf("%s R1 R2 R7 fmt=%0d len=%0d t=%0d got %b exp %b",
                                  tag, fmt, len, t, got, exp));
      if (t == 0 || t == 255)
        chk(user_o == usr, $sformatf("R10 user t=%0d got %h exp %h", t, user_o, usr));
      if (push_mid && t == 50) drive_nxt();
      if (push_mid && t == 51) smp_valid_i = 1'b0;
    end
    if (push_mid) begin
      for (int c = 0; c < 8; c++) smp[c] = nxt[c];
      usr = nusr;
    end
  endtask

  initial begin
    #1500000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    int seed = 1;
    rst_ni = 1'b0; fmt_i = 2'b10; mode_i = 2'b00; src_len_i = 2'b00;
    mute_i = 1'b0; smp_valid_i = 1'b0; smp_data_i = '0; user_i = '0;
    usr = '0;
    for (int c = 0; c < 8; c++) smp[c] = '0;
    repeat (5) @(negedge clk);
    chk({wclk_o, bclk_o, sdata_o, user_o} == '0,
        $sformatf("R12 reset outputs got %b exp 0", {wclk_o, bclk_o, sdata_o, user_o}));
    rst_ni = 1'b1;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      chk({wclk_o, bclk_o, sdata_o, user_o} == '0,
          $sformatf("R6 fmt reset outputs got %b exp 0", {wclk_o, bclk_o, sdata_o, user_o}));
    end
    fmt_i = 2'b01;
    @(negedge clk);
    chk(wclk_o && bclk_o, $sformatf("R6 restart got w=%b b=%b exp 1 1", wclk_o, bclk_o));

    // sweep: mode x format x source length
    for (int m = 0; m < 2; m++) begin
      mode_i  = 2'(m);
      drv_run = (m == 1);
      wper    = 256;
      for (int fi = 0; fi < 3; fi++) begin
        int f = (fi == 2) ? 3 : fi;
        string tg = (f == 0) ? "R3" : (f == 1) ? "R4" : "R5";
        for (int lc = 0; lc < 3; lc++) begin
          fmt_i = 2'(f); src_len_i = 2'(lc);
          push_set(seed, len_bits(lc));
          seed++;
          repeat (600) @(negedge clk);
          check_frame(f, lc, 1'b0, 1'b0, 0, tg);
          check_frame(f, lc, 1'b0, 1'b0, 0, {tg, " R9 repeat"});
        end
      end
      if (m == 1) begin
        @(posedge clk); rise_at = -1;
        repeat (600) @(negedge clk);
        @(posedge clk);
        chk(rise_at == 3, $sformatf("R8 slave latency got %0d exp 3", rise_at));
      end
    end

    // master ignores a foreign word clock
    mode_i = 2'b00; drv_run = 1'b1; wper = 200;
    repeat (1000) @(negedge clk);
    @(posedge clk);
    chk(per_meas == 256, $sformatf("R8 R2 master period got %0d exp 256", per_meas));
    drv_run = 1'b0;

    // mid-frame offer takes effect at the next frame
    fmt_i = 2'b00; src_len_i = 2'b00;
    push_set(seed, 24); seed++;
    repeat (600) @(negedge clk);
    check_frame(0, 0, 1'b0, 1'b1, seed, "R9 midframe");
    seed++;
    check_frame(0, 0, 1'b0, 1'b0, 0, "R9 next frame");

    // mute
    fmt_i = 2'b01;
    repeat (600) @(negedge clk);
    mute_i = 1'b1;
    check_frame(1, 0, 1'b1, 1'b0, 0, "R11 mute");
    mute_i = 1'b0;

    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule